// File: doc/BRIEF.md
# DRAM Address-Map Configuration Matcher

This block picks the address-mapping configuration index that a memory scheduler should use for a given DRAM geometry. It takes the detected column and row counts, a flag for a full 32-bit data bus and a code for the requested interleave ordering. It then walks a fixed 16-entry table of supported geometries and reports the first entry that fits, or an error when none fits.

A one-cycle `start_i` pulse captures the request and begins the walk. The block examines one table entry per clock. It raises `valid_o` with the index on the cycle after the first fitting entry, or raises `err_o` once all sixteen entries have been examined without a fit. The result then holds until the next start. Each ordering has its own fitting rule: exact geometry, a minimum row count, or columns that either match exactly or exceed the entry's columns with the rows matching exactly. On a narrow bus one column bit is taken up by the bus width, so the column count is reduced by one before any comparison.

Top module: `amap_cfg_matcher`

## Requirements
- R1: After reset `valid_o`, `err_o` and `idx_o` are all 0.
- R2: Ordering code 0 (column-bank-row-device) considers only entries 0..10, whose (rows, cols) are (13,10) (14,10) (15,10) (16,10) (14,11) (15,11) (16,11) (13,9) (14,9) (15,9) (16,9). An entry fits only when both its rows and its columns equal the request.
- R3: Ordering code 1 (column-row-bank-device) considers only entries 11..13, with (rows, cols) of (15,10) (14,11) (13,10). An entry fits when its columns are equal to the request and its rows are at most the requested rows.
- R4: Ordering code 2 (column-bank-device-row) considers only entries 14..15, with (rows, cols) of (16,10) (16,9). An entry fits when its columns equal the request, or when its columns are at most the request and its rows are equal to the request.
- R5: When `bus32_i` is 0, the effective column count is `col_i` minus 1. When `bus32_i` is 1, `col_i` is used unchanged.
- R6: The lowest fitting index wins. `valid_o` rises with `idx_o` = k exactly k+1 clock edges after the edge that samples `start_i`.
- R7: When no entry fits, `err_o` rises 16 edges after the start edge and `valid_o` stays 0. The two flags are never high together.
- R8: Ordering code 3 is unsupported. It never fits any entry and ends in `err_o` after the full walk.
- R9: Once a result is reported, `idx_o`, `valid_o` and `err_o` do not change until the next start, whatever the request inputs do.
- R10: A start that arrives while a walk is in progress, including in the cycle that would report the result, abandons that walk. Both flags are cleared on that edge and the new request is walked from entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle pulse; captures the request and begins the walk |
| col_i | input | COL_W | Detected column address bits |
| row_i | input | ROW_W | Detected row address bits |
| bus32_i | input | 1 | 1 = full 32-bit bus, 0 = narrow bus |
| scheme_i | input | 2 | Requested ordering: 0, 1, 2 valid, 3 unsupported |
| idx_o | output | 4 | Chosen configuration index |
| valid_o | output | 1 | A fitting index has been found |
| err_o | output | 1 | The walk ended without a fit |

## Verification
The two functions that can fall in one cycle are reporting a finished walk and accepting a new start. The bench pulses `start_i` on exactly the edge on which a pending walk would report entry 11. It then checks that `valid_o` is low after that edge, and that the new request's index arrives one edge later, as a walk from entry 0 would give. A separate restart in mid-walk confirms that the abandoned request never surfaces.

// File: rtl/amap_pkg.sv
package amap_pkg;
  localparam int ENTRIES = 16;
  localparam int IDX_W   = $clog2(ENTRIES);
  localparam int TCOL_W  = 4;
  localparam int TROW_W  = 5;

  typedef enum logic [1:0] {
    SCH_CBRD = 2'd0,
    SCH_CRBD = 2'd1,
    SCH_CBDR = 2'd2,
    SCH_RSVD = 2'd3
  } scheme_e;

  typedef struct packed {
    scheme_e             sch;
    logic [TROW_W-1:0]   rows;
    logic [TCOL_W-1:0]   cols;
  } entry_t;

  function automatic entry_t tbl_entry(input logic [IDX_W-1:0] i);
    entry_t e;
    case (i)
      4'd0:    e = '{SCH_CBRD, 5'd13, 4'd10};
      4'd1:    e = '{SCH_CBRD, 5'd14, 4'd10};
      4'd2:    e = '{SCH_CBRD, 5'd15, 4'd10};
      4'd3:    e = '{SCH_CBRD, 5'd16, 4'd10};
      4'd4:    e = '{SCH_CBRD, 5'd14, 4'd11};
      4'd5:    e = '{SCH_CBRD, 5'd15, 4'd11};
      4'd6:    e = '{SCH_CBRD, 5'd16, 4'd11};
      4'd7:    e = '{SCH_CBRD, 5'd13, 4'd9};
      4'd8:    e = '{SCH_CBRD, 5'd14, 4'd9};
      4'd9:    e = '{SCH_CBRD, 5'd15, 4'd9};
      4'd10:   e = '{SCH_CBRD, 5'd16, 4'd9};
      4'd11:   e = '{SCH_CRBD, 5'd15, 4'd10};
      4'd12:   e = '{SCH_CRBD, 5'd14, 4'd11};
      4'd13:   e = '{SCH_CRBD, 5'd13, 4'd10};
      4'd14:   e = '{SCH_CBDR, 5'd16, 4'd10};
      default: e = '{SCH_CBDR, 5'd16, 4'd9};
    endcase
    return e;
  endfunction
endpackage

// File: rtl/amap_rule.sv
module amap_rule
  import amap_pkg::*;
#(
  parameter int COL_W = 4,
  parameter int ROW_W = 5
) (
  input  logic [IDX_W-1:0] idx_i,
  input  scheme_e          sch_i,
  input  logic [COL_W-1:0] cols_i,
  input  logic [ROW_W-1:0] rows_i,
  output logic             hit_o
);
  entry_t           ent;
  logic [COL_W-1:0] e_cols;
  logic [ROW_W-1:0] e_rows;
  logic             col_eq, col_le, row_eq, row_le;

  assign ent    = tbl_entry(idx_i);
  assign e_cols = COL_W'(ent.cols);
  assign e_rows = ROW_W'(ent.rows);
  assign col_eq = (e_cols == cols_i);
  assign col_le = (e_cols <= cols_i);
  assign row_eq = (e_rows == rows_i);
  assign row_le = (e_rows <= rows_i);

  always_comb begin
    hit_o = 1'b0;
    if (ent.sch == sch_i) begin
      case (sch_i)
        SCH_CBRD: hit_o = col_eq && row_eq;
        SCH_CRBD: hit_o = col_eq && row_le;
        SCH_CBDR: hit_o = col_eq || (col_le && row_eq);
        default:  hit_o = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/amap_scan.sv
module amap_scan
  import amap_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             hit_i,
  output logic             run_o,
  output logic [IDX_W-1:0] ptr_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             valid_o,
  output logic             err_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic             run_q, valid_q, err_q;
  logic [IDX_W-1:0] ptr_q, idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      ptr_q   <= '0;
      idx_q   <= '0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else if (start_i) begin
      // restart wins over any result due this cycle
      run_q   <= 1'b1;
      ptr_q   <= '0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else if (run_q) begin
      if (hit_i) begin
        valid_q <= 1'b1;
        idx_q   <= ptr_q;
        run_q   <= 1'b0;
      end else if (ptr_q == LAST) begin
        err_q   <= 1'b1;
        run_q   <= 1'b0;
      end else begin
        ptr_q   <= ptr_q + 1'b1;
      end
    end
  end

  assign run_o   = run_q;
  assign ptr_o   = ptr_q;
  assign idx_o   = idx_q;
  assign valid_o = valid_q;
  assign err_o   = err_q;

  assert_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_q && err_q));

  assert_exhaust_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !start_i && !hit_i && ptr_q == LAST) |=> (err_q && !valid_q));

  assert_first_hit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !start_i && hit_i) |=> (valid_q && idx_q == $past(ptr_q)));

  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && !run_q) |=> ($stable(valid_q) && $stable(err_q) && $stable(idx_q)));

  assert_restart_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (run_q && !valid_q && !err_q && ptr_q == '0));
endmodule

// File: rtl/amap_cfg_matcher.sv
module amap_cfg_matcher
  import amap_pkg::*;
#(
  parameter int COL_W = 4,
  parameter int ROW_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic             bus32_i,
  input  logic [1:0]       scheme_i,
  output logic [3:0]       idx_o,
  output logic             valid_o,
  output logic             err_o
);
  scheme_e          sch_q;
  logic [COL_W-1:0] cols_q;
  logic [ROW_W-1:0] rows_q;
  logic [IDX_W-1:0] ptr, idx;
  logic             hit, run;

  // narrow bus consumes one column bit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sch_q  <= SCH_CBRD;
      cols_q <= '0;
      rows_q <= '0;
    end else if (start_i) begin
      sch_q  <= scheme_e'(scheme_i);
      cols_q <= bus32_i ? col_i : col_i - COL_W'(1);
      rows_q <= row_i;
    end
  end

  amap_rule #(.COL_W(COL_W), .ROW_W(ROW_W)) u_rule (
    .idx_i  (ptr),
    .sch_i  (sch_q),
    .cols_i (cols_q),
    .rows_i (rows_q),
    .hit_o  (hit)
  );

  amap_scan u_scan (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .hit_i   (hit),
    .run_o   (run),
    .ptr_o   (ptr),
    .idx_o   (idx),
    .valid_o (valid_o),
    .err_o   (err_o)
  );

  assign idx_o = 4'(idx);

  assert_rsvd_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && sch_q == SCH_RSVD) |-> !hit);

  assert_no_result_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run |-> (!valid_o && !err_o));
endmodule

// File: tb/tb_amap_cfg_matcher.sv
module tb_amap_cfg_matcher;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [3:0] col = '0;
  logic [4:0] row = '0;
  logic       bus32 = 1'b1;
  logic [1:0] scheme = '0;
  logic [3:0] idx;
  logic       valid, err;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  amap_cfg_matcher dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .col_i(col), .row_i(row),
    .bus32_i(bus32), .scheme_i(scheme), .idx_o(idx), .valid_o(valid), .err_o(err)
  );

  // {scheme, bus32, col, row, exp_err, exp_idx}
  localparam int NV = 15;
  localparam logic [16:0] VEC [NV] = '{
    {2'd0, 1'b1, 4'd10, 5'd13, 1'b0, 4'd0},
    {2'd0, 1'b1, 4'd11, 5'd16, 1'b0, 4'd6},
    {2'd0, 1'b1, 4'd9,  5'd16, 1'b0, 4'd10},
    {2'd0, 1'b1, 4'd9,  5'd12, 1'b1, 4'd0},
    {2'd0, 1'b0, 4'd11, 5'd15, 1'b0, 4'd2},
    {2'd0, 1'b0, 4'd10, 5'd14, 1'b0, 4'd8},
    {2'd1, 1'b1, 4'd10, 5'd16, 1'b0, 4'd11},
    {2'd1, 1'b1, 4'd10, 5'd13, 1'b0, 4'd13},
    {2'd1, 1'b1, 4'd11, 5'd13, 1'b1, 4'd0},
    {2'd2, 1'b1, 4'd10, 5'd12, 1'b0, 4'd14},
    {2'd2, 1'b1, 4'd9,  5'd13, 1'b0, 4'd15},
    {2'd2, 1'b1, 4'd11, 5'd16, 1'b0, 4'd14},
    {2'd2, 1'b1, 4'd11, 5'd15, 1'b1, 4'd0},
    {2'd3, 1'b1, 4'd10, 5'd13, 1'b1, 4'd0},
    {2'd2, 1'b0, 4'd10, 5'd12, 1'b0, 4'd15}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse(input logic [1:0] s, input logic b, input logic [3:0] c, input logic [4:0] r);
    scheme = s; bus32 = b; col = c; row = r; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output int lat);
    lat = 0;
    while (!(valid || err) && lat < 40) begin
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 5000) begin
        errors++; checks++;
        $display("FAIL watchdog: actual=%0d expected<=5000", cyc);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    int lat;
    repeat (3) @(negedge clk);
    check("R1 valid", valid, 0);
    check("R1 err", err, 0);
    check("R1 idx", idx, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [16:0] v;
      string tag;
      v = VEC[i];
      case (v[16:15])
        2'd0: tag = "R2";
        2'd1: tag = "R3";
        2'd2: tag = "R4";
        default: tag = "R8";
      endcase
      if (!v[14]) tag = {tag, "/R5"};
      if (v[4] && v[16:15] != 2'd3) tag = {tag, "/R7"};
      pulse(v[16:15], v[14], v[13:10], v[9:5]);
      wait_done(lat);
      if (v[4]) begin
        check({tag, " err"}, err, 1);
        check({tag, " valid"}, valid, 0);
        check({tag, " latency R7"}, lat, 16);
      end else begin
        check({tag, " valid"}, valid, 1);
        check({tag, " idx"}, idx, v[3:0]);
        check({tag, " latency R6"}, lat, v[3:0] + 1);
      end
      @(negedge clk);
    end

    // R9: result held while request inputs wander
    pulse(2'd0, 1'b1, 4'd11, 5'd15);
    wait_done(lat);
    check("R9 setup idx", idx, 5);
    for (int k = 0; k < 6; k++) begin
      scheme = 2'(k); col = 4'(k + 8); row = 5'(k + 12); bus32 = k[0];
      @(negedge clk);
    end
    check("R9 idx", idx, 5);
    check("R9 valid", valid, 1);
    check("R9 err", err, 0);

    // R10: restart in mid-walk
    pulse(2'd0, 1'b1, 4'd9, 5'd16);
    repeat (4) @(negedge clk);
    check("R10 mid valid", valid, 0);
    pulse(2'd0, 1'b1, 4'd10, 5'd14);
    wait_done(lat);
    check("R10 mid idx", idx, 1);
    check("R10 mid latency", lat, 2);

    // R10: start on the edge that would report entry 11
    pulse(2'd1, 1'b1, 4'd10, 5'd16);
    repeat (11) @(negedge clk);
    check("R10 pre valid", valid, 0);
    pulse(2'd0, 1'b1, 4'd10, 5'd13);
    check("R10 collide valid", valid, 0);
    check("R10 collide err", err, 0);
    @(negedge clk);
    check("R10 collide new valid", valid, 1);
    check("R10 collide new idx", idx, 0);

    // R10: restart clears an error result
    pulse(2'd3, 1'b1, 4'd10, 5'd13);
    wait_done(lat);
    check("R8 err", err, 1);
    pulse(2'd2, 1'b1, 4'd10, 5'd16);
    check("R10 err cleared", err, 0);
    wait_done(lat);
    check("R10 after err idx", idx, 14);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule